// File: doc/BRIEF.md
# Video Fetch Bus Stall Arbiter

This block decides, cycle by cycle, whether a shared memory bus belongs to the CPU or to a video fetch engine. The engine needs the bus on a fixed schedule across each raster line. On a badline it makes a run of 40 consecutive character-matrix fetches, each paired with a colour fetch. Each enabled sprite also needs a pointer fetch and a data fetch in a slot that starts near the end of the line and can spill into the start of the next line. A free-running counter gives the position within the line.

Two signals go to the CPU. `ba` is a bus-available warning that drives the CPU's ready input. It goes low three cycles before the first stolen cycle, stays low across stolen regions that are close together, and goes high again once no fetch is due within the next three cycles. `aec` goes low in stolen cycles, which gives the video engine both clock phases in those cycles. The CPU ignores ready while it writes, so it only halts at its first read after `ba` falls. The block follows this behaviour and reports which cycles the CPU really loses. It gives a per-cycle flag and a count of stalled cycles for each line.

Top module: `video_bus_arbiter`

## Requirements
- R1: `cycle` counts 0 to LINE_CYCLES-1 (default 63) and then wraps to 0. It is held at 0 during reset.
- R2: `aec` is low exactly in fetch cycles. With `badline` high, the fetch cycles are 14 to 53. For every set bit s of `sprite_en`, they also include cycles (57+2s) mod 63 and (58+2s) mod 63.
- R3: `ba` is low in any cycle where a fetch falls in the same cycle or in one of the next three cycles (cycle indices wrap modulo 63), and high in every other cycle.
- R4: When `ba` is low and `cpu_wr` is 0 (a read), `cpu_stall` is 1. After that, `cpu_stall` stays 1 in every cycle until `ba` goes high, whatever `cpu_wr` is.
- R5: When `ba` is low, the cycle is not a fetch cycle, `cpu_wr` is 1 and the CPU has not yet halted, `cpu_stall` is 0. The write goes through.
- R6: Every fetch cycle is a stalled cycle, so `aec` low implies `cpu_stall` high.
- R7: After cycle LINE_CYCLES-1, `line_done` pulses for one cycle. During that pulse, `line_stalls` holds the number of stalled cycles in the line that just ended. If the CPU always reads, this is 15 with `sprite_en`=0x3F and no badline, and 58 with `sprite_en`=0x3F and a badline.
- R8: During reset, `cycle`, `line_done` and `line_stalls` are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Bus cycle clock |
| rst_n | input | 1 | Active-low synchronous reset |
| badline | input | 1 | Current line needs matrix and colour fetches |
| sprite_en | input | SPRITES | One enable bit per sprite |
| cpu_wr | input | 1 | CPU access this cycle is a write |
| cycle | output | CW | Position within the line |
| ba | output | 1 | Bus-available warning to the CPU ready input |
| aec | output | 1 | Low when the video engine owns both phases |
| cpu_stall | output | 1 | CPU loses this cycle |
| line_done | output | 1 | One-cycle pulse after each line ends |
| line_stalls | output | CW | Stalled cycles in the line just ended |

## Verification
The main overlap is a CPU write landing in the three-cycle warning window. There the `ba` warning and the write exemption act in the same cycle, so the stall flag must stay low until the first read, and after that it must stay high. The bench provokes this with write bursts of up to three cycles that slide across the warning windows of the badline run and the sprite slots. A second overlap is the sprite slots wrapping over the line boundary in the same cycle that the line count is closed. This is exercised with masks whose slots straddle the wrap. Both cases are judged against a behavioural model, compared on every clock, and against fixed per-line stall counts.

// File: rtl/video_bus_arbiter.sv
module video_bus_arbiter #(
  parameter int LINE_CYCLES  = 63,
  parameter int MATRIX_START = 14,
  parameter int MATRIX_LEN   = 40,
  parameter int SPRITES      = 8,
  parameter int SPRITE_START = 57,
  parameter int SPRITE_SLOTS = 2,
  parameter int WARN         = 3,
  parameter int CW           = $clog2(LINE_CYCLES + 1)
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               badline,
  input  logic [SPRITES-1:0] sprite_en,
  input  logic               cpu_wr,
  output logic [CW-1:0]      cycle,
  output logic               ba,
  output logic               aec,
  output logic               cpu_stall,
  output logic               line_done,
  output logic [CW-1:0]      line_stalls
);

  localparam logic [CW-1:0] LAST = CW'(LINE_CYCLES - 1);

  function automatic logic fetch_at(input int c, input logic bl, input logic [SPRITES-1:0] en);
    logic hit;
    hit = bl && (c >= MATRIX_START) && (c < MATRIX_START + MATRIX_LEN);
    for (int s = 0; s < SPRITES; s++)
      for (int k = 0; k < SPRITE_SLOTS; k++)
        if (en[s] && c == (SPRITE_START + s * SPRITE_SLOTS + k) % LINE_CYCLES)
          hit = 1'b1;
    return hit;
  endfunction

  logic steal, warn, halted;
  logic [CW-1:0] acc;

  always_comb begin
    steal = fetch_at(int'(cycle), badline, sprite_en);
    warn  = 1'b0;
    for (int k = 0; k <= WARN; k++)
      warn = warn | fetch_at((int'(cycle) + k) % LINE_CYCLES, badline, sprite_en);
  end

  assign ba        = !warn;
  assign aec       = !steal;
  assign cpu_stall = steal || (!ba && (halted || !cpu_wr));

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      cycle       <= '0;
      halted      <= 1'b0;
      acc         <= '0;
      line_done   <= 1'b0;
      line_stalls <= '0;
    end else begin
      halted <= cpu_stall;
      if (cycle == LAST) begin
        cycle       <= '0;
        acc         <= '0;
        line_stalls <= acc + CW'(cpu_stall);
        line_done   <= 1'b1;
      end else begin
        cycle     <= cycle + 1'b1;
        acc       <= acc + CW'(cpu_stall);
        line_done <= 1'b0;
      end
    end
  end

endmodule

module video_bus_arbiter_chk #(
  parameter int LINE_CYCLES = 63,
  parameter int CW          = 6
) (
  input logic          clk,
  input logic          rst_n,
  input logic          cpu_wr,
  input logic [CW-1:0] cycle,
  input logic          ba,
  input logic          aec,
  input logic          cpu_stall,
  input logic          line_done
);
  // R1
  wrap_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (cycle == CW'(LINE_CYCLES - 1)) |=> (cycle == '0));
  // R3
  warn_cover_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !aec |-> !ba);
  // R6
  steal_stall_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !aec |-> cpu_stall);
  // R4
  hold_stall_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (cpu_stall && !ba) |=> (ba || cpu_stall));
  // R5
  write_slip_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!ba && aec && cpu_wr && !$past(cpu_stall) && $past(rst_n)) |-> !cpu_stall);
  // R7
  done_pos_chk: assert property (@(posedge clk) disable iff (!rst_n)
    line_done |-> ($past(cycle) == CW'(LINE_CYCLES - 1)));
  // R4
  free_when_ba_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ba |-> !cpu_stall);
endmodule

bind video_bus_arbiter video_bus_arbiter_chk #(.LINE_CYCLES(LINE_CYCLES), .CW(CW)) chk_i (.*);

// File: tb/video_bus_arbiter_test.sv
module video_bus_arbiter_test;
  localparam int CLK_PERIOD = 10;
  localparam int L = 63;
  localparam int LINES = 15;

  logic clk = 1'b0;
  always #(CLK_PERIOD / 2) clk = ~clk;

  logic       rst_n, badline, cpu_wr;
  logic [7:0] sprite_en;
  logic [5:0] cycle, line_stalls;
  logic       ba, aec, cpu_stall, line_done;

  video_bus_arbiter uut (
    .clk(clk), .rst_n(rst_n), .badline(badline), .sprite_en(sprite_en),
    .cpu_wr(cpu_wr), .cycle(cycle), .ba(ba), .aec(aec),
    .cpu_stall(cpu_stall), .line_done(line_done), .line_stalls(line_stalls));

  int checks = 0, errors = 0;
  bit finished = 0;

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual %0d expected %0d", req, act, exp);
    end
  endtask

  function automatic bit [L-1:0] fetch_map(input bit [7:0] m, input bit bl);
    bit [L-1:0] f = '0;
    if (bl) for (int c = 14; c < 54; c++) f[c] = 1'b1;
    for (int s = 0; s < 8; s++)
      if (m[s]) begin
        f[(57 + 2 * s) % L] = 1'b1;
        f[(58 + 2 * s) % L] = 1'b1;
      end
    return f;
  endfunction

  task automatic config_line(input int n);
    case (n / 3)
      0: begin sprite_en = 8'h3F; badline = 1'b0; end
      1: begin sprite_en = 8'h3F; badline = 1'b1; end
      2: begin sprite_en = 8'h81; badline = 1'b1; end
      3: begin sprite_en = 8'hFF; badline = 1'b0; end
      default: begin sprite_en = 8'h00; badline = 1'b0; end
    endcase
  endtask

  function automatic bit wr_pattern(input int n, input int step);
    case (n / 3)
      0, 1: return 1'b0;
      2, 4: return (step % 5) < 3;
      default: return (step % 7) < 2;
    endcase
  endfunction

  initial begin
    repeat (200000) @(posedge clk);
    if (!finished) begin
      errors++;
      $display("FAIL watchdog expired");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    int mc = 0, mcnt = 0, ln = 0, step = 0, last_cnt = 0;
    bit mh = 0;
    bit [L-1:0] f;
    bit st, bam, sm;
    rst_n = 1'b0; cpu_wr = 1'b0;
    config_line(0);
    repeat (3) @(negedge clk);
    // R8 reset state
    chk(cycle == 0, "R8 cycle in reset", cycle, 0);
    chk(line_done == 0, "R8 line_done in reset", line_done, 0);
    chk(line_stalls == 0, "R8 line_stalls in reset", line_stalls, 0);
    rst_n = 1'b1;
    while (ln < LINES) begin
      cpu_wr = wr_pattern(ln, step);
      #1;
      f   = fetch_map(sprite_en, badline);
      st  = f[mc];
      bam = !(f[mc] | f[(mc + 1) % L] | f[(mc + 2) % L] | f[(mc + 3) % L]);
      sm  = st || (!bam && (mh || !cpu_wr));
      chk(cycle == mc, "R1 cycle", cycle, mc);
      chk(aec == !st, "R2 aec", aec, !st);
      chk(ba == bam, "R3 ba", ba, bam);
      if (st)
        chk(cpu_stall == sm, "R6 stall in fetch cycle", cpu_stall, sm);
      else if (!bam && cpu_wr && !mh)
        chk(cpu_stall == sm, "R5 write slips through", cpu_stall, sm);
      else
        chk(cpu_stall == sm, "R4 stall hold", cpu_stall, sm);
      if (mc == 0 && ln > 0) begin
        chk(line_done == 1, "R7 line_done pulse", line_done, 1);
        chk(line_stalls == last_cnt, "R7 line_stalls", line_stalls, last_cnt);
      end else
        chk(line_done == 0, "R7 line_done idle", line_done, 0);
      mh = sm;
      step++;
      if (mc == L - 1) begin
        last_cnt = mcnt + int'(sm);
        if (ln < 3) chk(last_cnt == 15, "R7 table mask 3F no badline", last_cnt, 15);
        else if (ln < 6) chk(last_cnt == 58, "R7 table mask 3F badline", last_cnt, 58);
        else if (ln >= 12) chk(last_cnt == 0, "R7 table no fetches", last_cnt, 0);
        mcnt = 0; mc = 0; ln++;
        @(negedge clk);
        config_line(ln);
      end else begin
        mcnt += int'(sm); mc++;
        @(negedge clk);
      end
    end
    #1;
    chk(line_done == 1, "R7 final line_done", line_done, 1);
    chk(line_stalls == last_cnt, "R7 final line_stalls", line_stalls, last_cnt);
    finished = 1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule